// File: doc/BRIEF.md
# Serial Byte Command and String Router

This block sits behind a UART receiver and sorts the received byte stream as it arrives. Each byte comes with a one-cycle valid strobe. A byte from a fixed set of command codes becomes a one-entry command. A start marker opens capture mode. In capture mode the bytes that follow go into a string ring buffer, until a terminator byte closes the string. The terminator then produces a "string ready" entry in the command queue. Any byte that fits none of these cases is dropped. Every byte is finished in the cycle it arrives, so a new byte may be offered on every clock.

The foreground reads two show-ahead queues. The command queue holds 9-bit entries. Bit 8 clear means bits 7:0 are a command code. Bit 8 set means a string is complete, and bits 7:0 give its length in bytes. String bytes become readable only when their terminator is accepted, so a reader never sees part of a string. A string that grows past the length limit is rolled back. A string that runs out of buffer room is rolled back too. A new start marker in the middle of a string also rolls it back.

Top module: `byte_router`

## Requirements
- R1: After reset `cmd_empty` and `str_empty` are 1 and `ovf_flag` is 0.
- R2: Outside capture, a byte equal to one of the command codes (default 0x41, 0x42, 0x43, 0x44) and accepted on an edge appears as entry {1'b0, byte} at the queue tail after that edge.
- R3: Outside capture, a byte that is neither a command code nor the start code (0x24) changes neither queue. This includes the terminator (0x0A).
- R4: The start code opens capture. While capturing, every byte other than start and terminator is stored as string content, one byte per strobe, and no command entry is made for it, even when it is a command code.
- R5: A terminator during capture pushes entry {1'b1, length} and ends capture. In the same edge the stored bytes become readable on `str_data` in arrival order. Before that edge `str_empty` does not fall for them.
- R6: A content byte that arrives when MAX_STR_LEN bytes are already held discards the whole string and ends capture. No entry is made. The bytes that follow are routed as outside capture.
- R7: A start code during capture discards the partial string and starts a new empty string.
- R8: A command or string-ready push into a full command queue is dropped, and `ovf_flag` is set. The flag stays set until reset. If the dropped push was a string-ready entry, its string is discarded.
- R9: A read strobe on an empty queue has no effect. A non-empty queue shows its oldest entry until it is read.
- R10: Bytes may arrive on consecutive cycles, and each is routed in the cycle it arrives, with no stall.
- R11: A content byte that arrives when the string buffer has no free slot (counting unread and uncommitted bytes) discards the string and ends capture, in the same way as R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | BYTE_W | Received byte |
| rx_valid | input | 1 | rx_byte is valid this cycle |
| cmd_rd | input | 1 | Pop the head of the command queue |
| cmd_data | output | BYTE_W+1 | Head of the command queue: flag bit and payload |
| cmd_empty | output | 1 | Command queue holds no entry |
| str_rd | input | 1 | Pop the head of the string queue |
| str_data | output | BYTE_W | Oldest committed string byte |
| str_empty | output | 1 | No committed string byte is waiting |
| ovf_flag | output | 1 | Sticky: a command-queue push was dropped |

## Verification
The bench builds the router with a 4-entry command queue, a 16-byte string buffer and a 12-byte length limit. With these sizes, filling the command queue, overrunning the length limit and exhausting the string buffer each take only a handful of bytes. The last case needs one committed 10-byte string followed by a second string. Random traffic mixes command codes, markers and stray bytes with random reads of both queues, so rollbacks, commits and pops meet on the same edge.

// File: rtl/br_pkg.sv
package br_pkg;
   typedef enum logic [1:0] {
      BC_OTHER = 2'd0,
      BC_CMD   = 2'd1,
      BC_START = 2'd2,
      BC_TERM  = 2'd3
   } byte_class_e;
endpackage

// File: rtl/br_classify.sv
module br_classify
   import br_pkg::*;
#(
   parameter int                          BYTE_W     = 8,
   parameter int                          NUM_CMD    = 4,
   parameter logic [NUM_CMD*BYTE_W-1:0]   CMD_SET    = 32'h44434241,
   parameter logic [BYTE_W-1:0]           START_CODE = 8'h24,
   parameter logic [BYTE_W-1:0]           TERM_CODE  = 8'h0A
) (
   input  logic [BYTE_W-1:0] byte_in,
   output byte_class_e       cls
);
   logic [NUM_CMD-1:0] hit;

   for (genvar i = 0; i < NUM_CMD; i++) begin : g_code
      if (CMD_SET[i*BYTE_W +: BYTE_W] == START_CODE ||
          CMD_SET[i*BYTE_W +: BYTE_W] == TERM_CODE) begin : g_clash
         $error("command code collides with a marker code");
      end
      assign hit[i] = (byte_in == CMD_SET[i*BYTE_W +: BYTE_W]);
   end

   always_comb begin
      if (byte_in == START_CODE)     cls = BC_START;
      else if (byte_in == TERM_CODE) cls = BC_TERM;
      else if (|hit)                 cls = BC_CMD;
      else                           cls = BC_OTHER;
   end
endmodule

// File: rtl/br_ring_q.sv
module br_ring_q #(
   parameter int W     = 9,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wr_ptr, rd_ptr;
   logic [AW:0]  used;
   logic         do_push, do_pop;

   assign used    = wr_ptr - rd_ptr;
   assign full    = (used == (AW+1)'(DEPTH));
   assign empty   = (wr_ptr == rd_ptr);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/br_str_ring.sv
module br_str_ring #(
   parameter int W     = 8,
   parameter int DEPTH = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   input  logic         commit,
   input  logic         rollback,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         room
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   // wr_ptr: next free slot; base_ptr: end of committed data; rd_ptr: head
   logic [AW:0]  wr_ptr, base_ptr, rd_ptr;
   logic [AW:0]  held;
   logic         do_pop;

   assign held   = wr_ptr - rd_ptr;
   assign room   = (held != (AW+1)'(DEPTH));
   assign empty  = (rd_ptr == base_ptr);
   assign do_pop = pop && !empty;
   assign rdata  = mem[rd_ptr[AW-1:0]];

   always_ff @(posedge clk) begin
      if (wr_en && room) mem[wr_ptr[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         base_ptr <= '0;
         rd_ptr   <= '0;
      end else begin
         if (rollback)          wr_ptr <= base_ptr;
         else if (wr_en && room) wr_ptr <= wr_ptr + 1'b1;
         if (commit)            base_ptr <= wr_ptr;
         if (do_pop)            rd_ptr <= rd_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/byte_router.sv
module byte_router
   import br_pkg::*;
#(
   parameter int                        BYTE_W      = 8,
   parameter int                        NUM_CMD     = 4,
   parameter logic [NUM_CMD*BYTE_W-1:0] CMD_SET     = 32'h44434241,
   parameter logic [BYTE_W-1:0]         START_CODE  = 8'h24,
   parameter logic [BYTE_W-1:0]         TERM_CODE   = 8'h0A,
   parameter int                        CMD_DEPTH   = 16,
   parameter int                        STR_DEPTH   = 128,
   parameter int                        MAX_STR_LEN = 96
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rx_valid,
   input  logic              cmd_rd,
   output logic [BYTE_W:0]   cmd_data,
   output logic              cmd_empty,
   input  logic              str_rd,
   output logic [BYTE_W-1:0] str_data,
   output logic              str_empty,
   output logic              ovf_flag
);
   localparam int LEN_W   = $clog2(MAX_STR_LEN + 1);
   localparam int ENTRY_W = BYTE_W + 1;

   if (CMD_DEPTH < 2 || (CMD_DEPTH & (CMD_DEPTH - 1)) != 0) begin : g_bad_cmd_depth
      $error("CMD_DEPTH must be a power of two of at least 2");
   end
   if (STR_DEPTH < 2 || (STR_DEPTH & (STR_DEPTH - 1)) != 0) begin : g_bad_str_depth
      $error("STR_DEPTH must be a power of two of at least 2");
   end
   if (MAX_STR_LEN < 1 || LEN_W > BYTE_W) begin : g_bad_len
      $error("MAX_STR_LEN must fit the entry payload");
   end
   if (START_CODE == TERM_CODE) begin : g_bad_markers
      $error("start and terminator codes must differ");
   end

   byte_class_e        cls;
   logic               capturing, cap_nxt;
   logic [LEN_W-1:0]   len_q, len_nxt;
   logic               ovf_set;
   logic               cmd_push, cmd_full;
   logic [ENTRY_W-1:0] cmd_wdata;
   logic               s_wr, s_commit, s_roll, s_room;

   br_classify #(
      .BYTE_W(BYTE_W), .NUM_CMD(NUM_CMD), .CMD_SET(CMD_SET),
      .START_CODE(START_CODE), .TERM_CODE(TERM_CODE)
   ) cls_i (
      .byte_in(rx_byte),
      .cls    (cls)
   );

   always_comb begin
      cap_nxt   = capturing;
      len_nxt   = len_q;
      cmd_push  = 1'b0;
      cmd_wdata = '0;
      s_wr      = 1'b0;
      s_commit  = 1'b0;
      s_roll    = 1'b0;
      ovf_set   = 1'b0;
      if (rx_valid) begin
         if (capturing) begin
            unique case (cls)
               BC_START: begin
                  s_roll  = 1'b1;
                  len_nxt = '0;
               end
               BC_TERM: begin
                  cap_nxt = 1'b0;
                  if (!cmd_full) begin
                     cmd_push  = 1'b1;
                     cmd_wdata = {1'b1, BYTE_W'(len_q)};
                     s_commit  = 1'b1;
                  end else begin
                     s_roll  = 1'b1;
                     ovf_set = 1'b1;
                  end
               end
               default: begin
                  if (len_q == LEN_W'(MAX_STR_LEN) || !s_room) begin
                     s_roll  = 1'b1;
                     cap_nxt = 1'b0;
                  end else begin
                     s_wr    = 1'b1;
                     len_nxt = len_q + 1'b1;
                  end
               end
            endcase
         end else begin
            unique case (cls)
               BC_START: begin
                  cap_nxt = 1'b1;
                  len_nxt = '0;
               end
               BC_CMD: begin
                  if (!cmd_full) begin
                     cmd_push  = 1'b1;
                     cmd_wdata = {1'b0, rx_byte};
                  end else begin
                     ovf_set = 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         capturing <= 1'b0;
         len_q     <= '0;
         ovf_flag  <= 1'b0;
      end else begin
         capturing <= cap_nxt;
         len_q     <= len_nxt;
         if (ovf_set) ovf_flag <= 1'b1;
      end
   end

   br_ring_q #(.W(ENTRY_W), .DEPTH(CMD_DEPTH)) cmdq_i (
      .clk  (clk),
      .rst_n(rst_n),
      .push (cmd_push),
      .wdata(cmd_wdata),
      .pop  (cmd_rd),
      .rdata(cmd_data),
      .empty(cmd_empty),
      .full (cmd_full)
   );

   br_str_ring #(.W(BYTE_W), .DEPTH(STR_DEPTH)) strq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (s_wr),
      .wdata   (rx_byte),
      .commit  (s_commit),
      .rollback(s_roll),
      .pop     (str_rd),
      .rdata   (str_data),
      .empty   (str_empty),
      .room    (s_room)
   );
endmodule

// File: rtl/br_chk.sv
module br_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              cmd_rd,
   input logic [BYTE_W:0]   cmd_data,
   input logic              cmd_empty,
   input logic              str_rd,
   input logic [BYTE_W-1:0] str_data,
   input logic              str_empty,
   input logic              ovf_flag
);
   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   // R3
   no_spurious_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_empty && !rx_valid) |=> cmd_empty);

   // R5
   no_spurious_str_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (str_empty && !rx_valid) |=> str_empty);

   // R5
   str_with_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(str_empty) |-> !cmd_empty);

   // R9
   cmd_head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_empty && !cmd_rd) |=> (!cmd_empty && $stable(cmd_data)));

   // R9
   str_head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!str_empty && !str_rd) |=> (!str_empty && $stable(str_data)));
endmodule

bind byte_router br_chk #(.BYTE_W(BYTE_W)) chk_i (.*);

// File: tb/byte_router_tb_top.sv
module byte_router_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CD   = 4;
   localparam int SD   = 16;
   localparam int MAXL = 12;
   localparam logic [7:0] START = 8'h24;
   localparam logic [7:0] TERM  = 8'h0A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       rx_valid = 1'b0;
   logic       cmd_rd = 1'b0;
   logic       str_rd = 1'b0;
   logic [8:0] cmd_data;
   logic       cmd_empty;
   logic [7:0] str_data;
   logic       str_empty;
   logic       ovf_flag;

   int vectors = 0;
   int fails   = 0;
   bit done    = 0;
   string cur_tag = "R1";

   logic [8:0] mcmd[$];
   logic [7:0] mstr[$];
   logic [7:0] mpend[$];
   bit mcap, movf;

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_router #(
      .CMD_DEPTH(CD), .STR_DEPTH(SD), .MAX_STR_LEN(MAXL)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
      .cmd_rd(cmd_rd), .cmd_data(cmd_data), .cmd_empty(cmd_empty),
      .str_rd(str_rd), .str_data(str_data), .str_empty(str_empty),
      .ovf_flag(ovf_flag)
   );

   function automatic bit is_cmd(logic [7:0] b);
      return (b == 8'h41 || b == 8'h42 || b == 8'h43 || b == 8'h44);
   endfunction

   function automatic void compare(string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s act=%h exp=%h", cur_tag, what, act, exp);
      end
   endfunction

   function automatic void check_all();
      compare("cmd_empty", int'(cmd_empty), int'(mcmd.size() == 0));
      if (mcmd.size() != 0) compare("cmd_data", int'(cmd_data), int'(mcmd[0]));
      compare("str_empty", int'(str_empty), int'(mstr.size() == 0));
      if (mstr.size() != 0) compare("str_data", int'(str_data), int'(mstr[0]));
      compare("ovf_flag", int'(ovf_flag), int'(movf));
   endfunction

   function automatic void mstep(bit v, logic [7:0] b, bit cr, bit sr);
      bit         cfull = (mcmd.size() >= CD);
      int         used  = mstr.size() + mpend.size();
      bit         do_push = 0;
      bit         do_commit = 0;
      logic [8:0] pv = '0;
      if (v) begin
         if (mcap) begin
            if (b == START) mpend.delete();
            else if (b == TERM) begin
               mcap = 0;
               if (!cfull) begin
                  do_push = 1; do_commit = 1;
                  pv = {1'b1, 8'(mpend.size())};
               end else begin
                  mpend.delete(); movf = 1;
               end
            end else if (mpend.size() >= MAXL || used >= SD) begin
               mpend.delete(); mcap = 0;
            end else mpend.push_back(b);
         end else if (b == START) mcap = 1;
         else if (is_cmd(b)) begin
            if (!cfull) begin do_push = 1; pv = {1'b0, b}; end
            else movf = 1;
         end
      end
      if (cr && mcmd.size() != 0) void'(mcmd.pop_front());
      if (sr && mstr.size() != 0) void'(mstr.pop_front());
      if (do_push) mcmd.push_back(pv);
      if (do_commit) begin
         foreach (mpend[i]) mstr.push_back(mpend[i]);
         mpend.delete();
      end
   endfunction

   task automatic cyc(bit v, logic [7:0] b, bit cr, bit sr);
      rx_valid = v; rx_byte = b; cmd_rd = cr; str_rd = sr;
      mstep(v, b, cr, sr);
      @(posedge clk);
      @(negedge clk);
      check_all();
   endtask

   task automatic send(logic [7:0] b);
      cyc(1'b1, b, 1'b0, 1'b0);
   endtask

   task automatic drain();
      while (mcmd.size() != 0 || mstr.size() != 0) cyc(1'b0, 8'h00, 1'b1, 1'b1);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rx_valid = 0; cmd_rd = 0; str_rd = 0;
      mcmd.delete(); mstr.delete(); mpend.delete(); mcap = 0; movf = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cur_tag = "R1";
      check_all();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      do_reset();

      // R2: command codes outside capture
      cur_tag = "R2";
      send(8'h41); send(8'h44); cyc(0, 0, 0, 0);
      compare("R2 head", int'(cmd_data), 9'h041);
      drain();

      // R3: stray bytes and a lone terminator are dropped
      cur_tag = "R3";
      send(8'h00); send(TERM); send(8'h7F); send(8'h45);
      drain();

      // R4 R5: string containing a command code
      cur_tag = "R4";
      send(START); send(8'h41); send(8'h78);
      compare("R4 no entry", int'(cmd_empty), 1);
      send(8'h42);
      cur_tag = "R5";
      compare("R5 str hidden", int'(str_empty), 1);
      send(TERM);
      compare("R5 entry", int'(cmd_data), 9'h103);
      compare("R5 first byte", int'(str_data), 8'h41);
      drain();

      // R6: overlong string is dropped, command mode resumes
      cur_tag = "R6";
      send(START);
      for (int i = 0; i < MAXL + 1; i++) send(8'h30 + 8'(i));
      send(8'h43); send(TERM);
      compare("R6 cmd after drop", int'(cmd_data), 9'h043);
      drain();

      // R7: start inside capture restarts the string
      cur_tag = "R7";
      send(START); send(8'h31); send(8'h32); send(START); send(8'h39); send(TERM);
      compare("R7 entry", int'(cmd_data), 9'h101);
      compare("R7 byte", int'(str_data), 8'h39);
      drain();

      // R9: reads on empty queues
      cur_tag = "R9";
      repeat (3) cyc(0, 0, 1, 1);

      // R11: string buffer exhausted by unread data
      cur_tag = "R11";
      send(START);
      for (int i = 0; i < 10; i++) send(8'h60 + 8'(i));
      send(TERM);
      cyc(0, 0, 1, 0);
      send(START);
      for (int i = 0; i < 7; i++) send(8'h70 + 8'(i));
      send(TERM);
      compare("R11 no entry", int'(cmd_empty), 1);
      drain();

      // R8: overflow of the command queue
      cur_tag = "R8";
      for (int i = 0; i < CD + 1; i++) send(8'h42);
      compare("R8 ovf", int'(ovf_flag), 1);
      send(START); send(8'h55); send(TERM);
      drain();
      repeat (3) cyc(0, 0, 0, 0);
      do_reset();

      // R10: back-to-back random traffic
      cur_tag = "R10";
      for (int n = 0; n < 4000; n++) begin
         int r = int'($urandom % 16);
         logic [7:0] b;
         if (r < 5)       b = 8'h41 + 8'($urandom % 4);
         else if (r == 5) b = START;
         else if (r == 6) b = TERM;
         else             b = 8'($urandom);
         cyc(($urandom % 5) != 0, b, ($urandom % 3) == 0, ($urandom % 2) == 0);
      end
      drain();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule